// File: doc/BRIEF.md
# Two-Operand Integer Execute Stage

This block performs the register-to-register arithmetic and logic work of a 32-bit processor that has sixteen general registers. For each strobed instruction word, the issue logic supplies two operand values. The first is the value of the register that is also the destination. The second is the value of the source register. The block decodes the opcode and computes the result. One clock later it presents the result, the destination register index and a write-enable.

The block covers the following operations:
- add, subtract, AND, OR and XOR;
- bitwise complement and two's-complement negation;
- three shift kinds;
- byte and half-word sign and zero extension;
- the low 32 bits of a product, and the high 32 bits of unsigned and signed products;
- signed and unsigned quotient and remainder;
- a short form that adds or subtracts an 8-bit unsigned immediate.

A zero divisor suppresses the write and raises a one-cycle exception pulse. The four reserved opcodes raise an illegal-instruction pulse. All other encodings belong to other units, so the block ignores them without writing.

Top module: `exec_rr`

## Requirements
- R1: The result, write-enable, destination index and both flags appear on the clock edge that follows the cycle in which `op_valid` is high, and `res_valid` is high for exactly that one cycle. When `op_valid` is low, `res_valid`, `wr_en`, `illegal` and `div_zero` are low in the following cycle. After reset, all outputs are zero.
- R2: A word with bit 15 clear uses bits 15:8 as its opcode. Opcode 0x05 writes a+b, 0x29 writes a-b, 0x26 writes a AND b, 0x2B writes a OR b and 0x2E writes a XOR b. All arithmetic wraps modulo 2^32.
- R3: Opcode 0x2C writes the bitwise complement of b, and 0x2A writes the two's-complement negation of b. The first operand has no effect on either result.
- R4: Opcode 0x27 shifts a right logically, 0x28 shifts a left, and 0x2D shifts a right arithmetically. The shift amount is b[4:0] only, so the upper bits of b have no effect.
- R5: Opcode 0x10 sign-extends b[7:0], 0x11 sign-extends b[15:0], 0x12 zero-extends b[7:0] and 0x13 zero-extends b[15:0].
- R6: Opcode 0x2F writes the low 32 bits of a*b. Opcode 0x14 writes bits 63:32 of the unsigned 64-bit product. Opcode 0x15 writes bits 63:32 of the product of the operands taken as signed.
- R7: Opcodes 0x31 and 0x33 give the signed quotient and remainder, and 0x32 and 0x34 give the unsigned quotient and remainder. Quotients truncate toward zero, and a remainder takes the sign of the dividend. Dividing 0x80000000 by 0xFFFFFFFF as signed values gives quotient 0x80000000 and remainder 0.
- R8: Any of the four divide or remainder opcodes with b equal to zero leaves `wr_en` low and pulses `div_zero`.
- R9: A word whose bits 15:14 are 2'b10 is the short form. Bits 13:12 select the operation, bits 11:8 give the register (which is both `res_dst` and the source of a), and bits 7:4 have no effect on `res_dst`. Selector 0 writes a plus the zero-extended bits 7:0, selector 1 writes a minus that value, and selectors 2 and 3 write nothing.
- R10: For words with bit 15 clear, `res_dst` is bits 7:4 of the instruction.
- R11: Opcodes 0x00, 0x16, 0x17 and 0x18 pulse `illegal` and leave `wr_en` low.
- R12: Any other opcode with bit 15 clear, and any word whose bits 15:14 are 2'b11, gives `res_valid` with `wr_en`, `illegal` and `div_zero` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation strobe |
| instr | input | 16 | Instruction word |
| src_a | input | 32 | Value of the destination/first register |
| src_b | input | 32 | Value of the second register |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 32 | Result value |
| res_dst | output | 4 | Destination register index |
| wr_en | output | 1 | Register write-enable |
| illegal | output | 1 | Reserved-opcode pulse |
| div_zero | output | 1 | Zero-divisor pulse |

## Verification
The bench probes the most error-prone corners directly:
- The signed overflow quotient 0x80000000 / -1. A design that negates through a narrow path would return the wrong remainder sign or garbage.
- Remainders with a negative dividend or a negative divisor. These expose any rounding that is not toward zero.
- Shift amounts of 32 and above, which a design would mishandle if it used the whole second operand.
- Signed high products of negative operands. A design that zero-extended before multiplying would return the unsigned high half.

Zero divisors, reserved opcodes, short-form selectors 2 and 3, and foreign encodings check that no write escapes. The short form is checked for the immediate being zero-extended rather than sign-extended, and for the destination coming from bits 11:8 instead of 7:4.

// File: rtl/exec_rr.sv
`timescale 1ns/1ps
module exec_rr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [15:0]  instr,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic [3:0]   res_dst,
  output logic         wr_en,
  output logic         illegal,
  output logic         div_zero
);
  localparam int SHW = $clog2(W);

  wire       long_f  = ~instr[15];
  wire       short_f = instr[15] & ~instr[14];
  wire [7:0] opc     = instr[15:8];
  wire [SHW-1:0] sh  = src_b[SHW-1:0];

  wire [2*W-1:0] prod_u = {{W{1'b0}}, src_a} * {{W{1'b0}}, src_b};
  wire [2*W-1:0] prod_s = {{W{src_a[W-1]}}, src_a} * {{W{src_b[W-1]}}, src_b};

  wire         sgn     = opc[0];
  wire [W-1:0] mag_a   = (sgn & src_a[W-1]) ? -src_a : src_a;
  wire [W-1:0] mag_b   = (sgn & src_b[W-1]) ? -src_b : src_b;
  wire         b_zero  = (src_b == '0);
  wire [W-1:0] div_b   = b_zero ? {{(W-1){1'b0}}, 1'b1} : mag_b;
  wire [W-1:0] quo_m   = mag_a / div_b;
  wire [W-1:0] rem_m   = mag_a % div_b;
  wire [W-1:0] quo     = (sgn & (src_a[W-1] ^ src_b[W-1])) ? -quo_m : quo_m;
  wire [W-1:0] rem     = (sgn & src_a[W-1]) ? -rem_m : rem_m;

  wire [W-1:0] imm     = {{(W-8){1'b0}}, instr[7:0]};

  logic [W-1:0] res_c;
  logic         we_c, ill_c, dz_c;
  wire  [3:0]   dst_c = short_f ? instr[11:8] : instr[7:4];

  always_comb begin
    res_c = '0;
    we_c  = 1'b0;
    ill_c = 1'b0;
    dz_c  = 1'b0;
    if (long_f) begin
      we_c = 1'b1;
      case (opc)
        8'h05: res_c = src_a + src_b;
        8'h29: res_c = src_a - src_b;
        8'h26: res_c = src_a & src_b;
        8'h2B: res_c = src_a | src_b;
        8'h2E: res_c = src_a ^ src_b;
        8'h2C: res_c = ~src_b;
        8'h2A: res_c = -src_b;
        8'h27: res_c = src_a >> sh;
        8'h28: res_c = src_a << sh;
        8'h2D: res_c = $unsigned($signed(src_a) >>> sh);
        8'h10: res_c = {{(W-8){src_b[7]}}, src_b[7:0]};
        8'h11: res_c = {{(W-16){src_b[15]}}, src_b[15:0]};
        8'h12: res_c = {{(W-8){1'b0}}, src_b[7:0]};
        8'h13: res_c = {{(W-16){1'b0}}, src_b[15:0]};
        8'h2F: res_c = prod_u[W-1:0];
        8'h14: res_c = prod_u[2*W-1:W];
        8'h15: res_c = prod_s[2*W-1:W];
        8'h31, 8'h32: begin
          res_c = quo;
          we_c  = ~b_zero;
          dz_c  = b_zero;
        end
        8'h33, 8'h34: begin
          res_c = rem;
          we_c  = ~b_zero;
          dz_c  = b_zero;
        end
        8'h00, 8'h16, 8'h17, 8'h18: begin
          we_c  = 1'b0;
          ill_c = 1'b1;
        end
        default: we_c = 1'b0;
      endcase
    end else if (short_f) begin
      case (instr[13:12])
        2'd0: begin res_c = src_a + imm; we_c = 1'b1; end
        2'd1: begin res_c = src_a - imm; we_c = 1'b1; end
        default: we_c = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_dst   <= '0;
      wr_en     <= 1'b0;
      illegal   <= 1'b0;
      div_zero  <= 1'b0;
    end else begin
      res_valid <= op_valid;
      wr_en     <= op_valid & we_c;
      illegal   <= op_valid & ill_c;
      div_zero  <= op_valid & dz_c;
      if (op_valid) begin
        res_data <= res_c;
        res_dst  <= dst_c;
      end
    end
  end

  // R1
  strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !(res_valid | wr_en | illegal | div_zero));
  // R8
  zero_div_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> (!wr_en && res_valid));
  // R11
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wr_en && !div_zero && res_valid));
  // R1
  write_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> res_valid);
endmodule

// File: tb/sim_exec_rr.sv
`timescale 1ns/1ps
module sim_exec_rr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic        res_valid, wr_en, illegal, div_zero;
  logic [31:0] res_data;
  logic [3:0]  res_dst;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exec_rr u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .res_valid(res_valid), .res_data(res_data),
    .res_dst(res_dst), .wr_en(wr_en), .illegal(illegal), .div_zero(div_zero)
  );

  // {illegal, div_zero, we, dst[3:0], data[31:0]}
  function automatic logic [38:0] model(input logic [15:0] ins, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    logic we, ill, dz;
    logic [3:0] d;
    longint sa, sb, q;
    logic [63:0] p;
    r = '0; we = 1'b0; ill = 1'b0; dz = 1'b0; d = ins[7:4];
    sa = $signed(a);
    sb = $signed(b);
    if (!ins[15]) begin
      we = 1'b1;
      case (ins[15:8])
        8'h05: r = a + b;
        8'h29: r = a - b;
        8'h26: r = a & b;
        8'h2B: r = a | b;
        8'h2E: r = a ^ b;
        8'h2C: r = ~b;
        8'h2A: r = 32'd0 - b;
        8'h27: r = a >> b[4:0];
        8'h28: r = a << b[4:0];
        8'h2D: begin q = sa >>> b[4:0]; r = q[31:0]; end
        8'h10: r = {{24{b[7]}}, b[7:0]};
        8'h11: r = {{16{b[15]}}, b[15:0]};
        8'h12: r = {24'd0, b[7:0]};
        8'h13: r = {16'd0, b[15:0]};
        8'h2F: begin p = {32'd0, a} * {32'd0, b}; r = p[31:0]; end
        8'h14: begin p = {32'd0, a} * {32'd0, b}; r = p[63:32]; end
        8'h15: begin q = sa * sb; r = q[63:32]; end
        8'h31, 8'h32, 8'h33, 8'h34: begin
          if (b == 0) begin we = 1'b0; dz = 1'b1; end
          else if (ins[8]) begin
            q = (ins[9]) ? sa % sb : sa / sb;
            r = q[31:0];
          end else begin
            r = (ins[10]) ? a % b : a / b;
          end
        end
        8'h00, 8'h16, 8'h17, 8'h18: begin we = 1'b0; ill = 1'b1; end
        default: we = 1'b0;
      endcase
    end else if (!ins[14]) begin
      d = ins[11:8];
      case (ins[13:12])
        2'd0: begin r = a + {24'd0, ins[7:0]}; we = 1'b1; end
        2'd1: begin r = a - {24'd0, ins[7:0]}; we = 1'b1; end
        default: we = 1'b0;
      endcase
    end
    return {ill, dz, we, d, r};
  endfunction

  task automatic do_op(input string req, input logic [15:0] ins, input logic [31:0] a, input logic [31:0] b);
    logic [38:0] e;
    logic ok;
    e = model(ins, a, b);
    @(negedge clk);
    instr = ins; src_a = a; src_b = b; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    checks++;
    ok = res_valid && (illegal == e[38]) && (div_zero == e[37]) && (wr_en == e[36]);
    if (e[36]) ok = ok && (res_dst == e[35:32]) && (res_data == e[31:0]);
    if (!ok) begin
      errors++;
      $display("FAIL %s instr=%h a=%h b=%h: got v=%b ill=%b dz=%b we=%b dst=%h data=%h, exp v=1 ill=%b dz=%b we=%b dst=%h data=%h",
               req, ins, a, b, res_valid, illegal, div_zero, wr_en, res_dst, res_data,
               e[38], e[37], e[36], e[35:32], e[31:0]);
    end
  endtask

  function automatic string req_of(input logic [7:0] op);
    case (op)
      8'h05, 8'h29, 8'h26, 8'h2B, 8'h2E: return "R2";
      8'h2C, 8'h2A: return "R3";
      8'h27, 8'h28, 8'h2D: return "R4";
      8'h10, 8'h11, 8'h12, 8'h13: return "R5";
      8'h2F, 8'h14, 8'h15: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [22];
    ops = '{8'h05, 8'h29, 8'h26, 8'h2B, 8'h2E, 8'h2C, 8'h2A, 8'h27, 8'h28, 8'h2D,
            8'h10, 8'h11, 8'h12, 8'h13, 8'h2F, 8'h14, 8'h15, 8'h31, 8'h32, 8'h33,
            8'h34, 8'h05};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    checks++;
    if (res_valid || wr_en || illegal || div_zero || res_data != 0 || res_dst != 0) begin
      errors++;
      $display("FAIL R1 reset state: got v=%b we=%b ill=%b dz=%b data=%h dst=%h, exp all zero",
               res_valid, wr_en, illegal, div_zero, res_data, res_dst);
    end
    rst_n = 1'b1;

    // R2 wrap
    do_op("R2", 16'h05_3A, 32'hFFFF_FFFF, 32'h0000_0002);
    do_op("R2", 16'h29_10, 32'h0000_0000, 32'h0000_0001);
    // R1 strobe drops afterwards
    @(negedge clk);
    checks++;
    if (res_valid || wr_en) begin
      errors++;
      $display("FAIL R1 idle cycle: got v=%b we=%b, exp 0 0", res_valid, wr_en);
    end
    // R3 first operand ignored
    do_op("R3", 16'h2C_45, 32'h1234_5678, 32'h0F0F_0000);
    do_op("R3", 16'h2A_45, 32'hDEAD_BEEF, 32'h0000_0001);
    // R4 upper bits of amount ignored
    do_op("R4", 16'h27_12, 32'h8000_0000, 32'hFFFF_FFE1);
    do_op("R4", 16'h28_12, 32'h0000_0003, 32'h0000_0020);
    do_op("R4", 16'h2D_12, 32'h8000_0010, 32'h0000_0024);
    // R5
    do_op("R5", 16'h10_21, 32'h0, 32'h1234_5680);
    do_op("R5", 16'h11_21, 32'h0, 32'h0000_8001);
    do_op("R5", 16'h12_21, 32'h0, 32'hFFFF_FF80);
    do_op("R5", 16'h13_21, 32'h0, 32'hFFFF_8001);
    // R6 negative signed high product
    do_op("R6", 16'h15_77, 32'hFFFF_FFFF, 32'h0000_0002);
    do_op("R6", 16'h14_77, 32'hFFFF_FFFF, 32'h0000_0002);
    do_op("R6", 16'h15_77, 32'h8000_0000, 32'h8000_0000);
    // R7 overflow and signs
    do_op("R7", 16'h31_33, 32'h8000_0000, 32'hFFFF_FFFF);
    do_op("R7", 16'h33_33, 32'h8000_0000, 32'hFFFF_FFFF);
    do_op("R7", 16'h31_33, 32'hFFFF_FFF9, 32'h0000_0002);
    do_op("R7", 16'h33_33, 32'hFFFF_FFF9, 32'h0000_0002);
    do_op("R7", 16'h33_33, 32'h0000_0007, 32'hFFFF_FFFE);
    do_op("R7", 16'h32_33, 32'hFFFF_FFF9, 32'h0000_0002);
    do_op("R7", 16'h34_33, 32'hFFFF_FFF9, 32'h0000_0010);
    // R8 zero divisor
    do_op("R8", 16'h31_4C, 32'h0000_0005, 32'h0);
    do_op("R8", 16'h34_4C, 32'h0000_0005, 32'h0);
    // R9 short form
    do_op("R9", 16'h8_5_FF, 32'h0000_0001, 32'h0);
    do_op("R9", 16'h9_A_80, 32'h0000_0010, 32'h0);
    do_op("R9", 16'hA_3_01, 32'h0000_0010, 32'h0);
    do_op("R9", 16'hB_3_01, 32'h0000_0010, 32'h0);
    // R10
    do_op("R10", 16'h05_E0, 32'h1, 32'h2);
    // R11
    do_op("R11", 16'h00_11, 32'h1, 32'h2);
    do_op("R11", 16'h16_11, 32'h1, 32'h2);
    do_op("R11", 16'h17_11, 32'h1, 32'h2);
    do_op("R11", 16'h18_11, 32'h1, 32'h2);
    // R12
    do_op("R12", 16'h0A_11, 32'h1, 32'h2);
    do_op("R12", 16'h35_11, 32'h1, 32'h2);
    do_op("R12", 16'hC0_05, 32'h1, 32'h2);

    for (int i = 0; i < 2000; i++) begin
      logic [7:0] op;
      logic [31:0] a, b;
      op = ops[$urandom_range(0, 21)];
      a = $urandom;
      b = $urandom;
      case ($urandom_range(0, 7))
        0: b = 32'h0;
        1: b = 32'hFFFF_FFFF;
        2: a = 32'h8000_0000;
        3: b = $urandom_range(0, 40);
        default: ;
      endcase
      if ($urandom_range(0, 9) == 0)
        do_op("R9", {2'b10, 1'b0, 1'($urandom_range(0, 1)), 4'($urandom), 8'($urandom)}, a, b);
      else
        do_op(req_of(op), {op, 8'($urandom)}, a, b);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule